// File: doc/BRIEF.md
# Boundary-Gated Interrupt Unit with Shadow Stack Buffer

This block sits between a small 8-bit core's stack logic, its external stack memory and its interrupt inputs. Pushes and pops issued inside a straight run of code land in a small on-chip LIFO. They cause no memory traffic until that LIFO overflows or underflows. Interrupt requests are looked at only when a taken control-flow instruction is reported. Every run of code between two taken transfers is therefore atomic without any mask flag or enable/disable instruction.

At each taken control-flow boundary, all buffered bytes are written out to the external stack. This keeps the memory image consistent and gives the next subroutine, branch target or loop body the whole buffer depth. If a request was present at that boundary, the accept pulse follows as soon as the write-out completes, so interrupt latency grows with the number of buffered bytes. A non-maskable request still waits for a boundary. When both kinds are present, the non-maskable one is the one reported.

The core stalls while `busy_o` is high. It must not raise push and pop in the same cycle.

Top module: `defer_irq_stack`

## Requirements
- R1: While the buffer holds fewer than DEPTH bytes, a push stores its byte with no external memory cycle. While it holds at least one byte, a pop returns the most recently pushed byte on `pop_data_o` in the same cycle, with no external memory cycle. `sp_o` is unchanged in both cases.
- R2: A push while the buffer holds DEPTH bytes writes the oldest buffered byte to external memory at address `sp_o` in that cycle, keeps the new byte, and decrements `sp_o` at the clock edge.
- R3: A pop while the buffer is empty drives an external read at address `sp_o`+1 and returns `mem_rdata_i` on `pop_data_o` in the same cycle. `sp_o` increments at the clock edge.
- R4: An instruction reported with class 2'b00 (straight) or 2'b10 (conditional not taken) never starts a write-out and never causes an interrupt accept, whatever `irq_i` and `nmi_i` do.
- R5: An instruction reported with class 2'b01 (taken control flow) while `busy_o` is low starts a write-out of the N buffered bytes if N > 0. Starting the next cycle, `busy_o` is high for exactly N cycles. Each such cycle writes one byte, oldest first, at `sp_o`, and `sp_o` decrements after each write. Afterwards, DEPTH pushes fit without any external write.
- R6: `irq_i` and `nmi_i` are sampled only in the cycle of a taken boundary. If either is high there, `irq_ack_o` pulses for one cycle, in the first cycle after the boundary in which `busy_o` is low. A request that is absent in the boundary cycle is never accepted.
- R7: `irq_nmi_o` is high together with `irq_ack_o` when `nmi_i` was high at the sampling boundary, including when `irq_i` was high as well. It is low for an accept caused by `irq_i` alone.
- R8: Push, pop and instruction reports are ignored while `busy_o` is high.
- R9: Asserting `rst_ni` low at once empties the buffer, ends any write-out, sets `sp_o` to SP_RST and discards a sampled request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Push strobe |
| pop_i | input | 1 | Pop strobe |
| push_data_i | input | DATA_W | Byte to push |
| pop_data_o | output | DATA_W | Popped byte, valid in the pop cycle |
| instr_valid_i | input | 1 | An instruction completes this cycle |
| instr_cls_i | input | 2 | Instruction class: 00 straight, 01 taken, 10 not taken |
| irq_i | input | 1 | Maskable request level |
| nmi_i | input | 1 | Non-maskable request level |
| irq_ack_o | output | 1 | Interrupt accept pulse |
| irq_nmi_o | output | 1 | Accepted request is non-maskable |
| busy_o | output | 1 | Write-out in progress; core must stall |
| sp_o | output | SP_W | External stack pointer |
| mem_we_o | output | 1 | External stack write |
| mem_re_o | output | 1 | External stack read |
| mem_addr_o | output | SP_W | External stack address |
| mem_wdata_o | output | DATA_W | External write data |
| mem_rdata_i | input | DATA_W | External read data, same cycle |

## Verification
The bench builds the block with DEPTH=4, SP_W=8 and SP_RST=0x20. The shallow depth means a spill occurs on the fifth push, and an underflow read after only a few pops. A full-depth write-out therefore takes four visible busy cycles, so overflow, underflow, full write-out and write-out-delayed accepts all fit in a short run. The reset value away from the address ends lets the bench see the decrement on spill and write-out and the increment on underflow as plain addresses on the memory port.

// File: rtl/dis_pkg.sv
package dis_pkg;
  typedef enum logic [1:0] {
    CLS_STRAIGHT  = 2'b00,
    CLS_TAKEN     = 2'b01,
    CLS_NOT_TAKEN = 2'b10,
    CLS_RSVD      = 2'b11
  } instr_cls_e;
endpackage

// File: rtl/dis_boundary_dec.sv
module dis_boundary_dec
  import dis_pkg::*;
(
  input  logic       instr_valid_i,
  input  logic [1:0] instr_cls_i,
  input  logic       busy_i,
  output logic       boundary_o
);
  always_comb begin
    boundary_o = instr_valid_i && !busy_i && (instr_cls_i == CLS_TAKEN);
  end
endmodule

// File: rtl/dis_shadow_buf.sv
module dis_shadow_buf #(
  parameter int          DEPTH  = 8,
  parameter int          DATA_W = 8,
  parameter int          SP_W   = 8,
  parameter logic [SP_W-1:0] SP_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              flush_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic              busy_o,
  output logic [SP_W-1:0]   sp_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [SP_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  // DEPTH must be a power of two >= 2 so slot indices wrap naturally
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0]  head_q, head_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SP_W-1:0]   sp_q, sp_d;
  logic              fl_q, fl_d;

  logic             full, empty, do_push, do_pop;
  logic [PTR_W-1:0] top_idx, tail_idx;

  always_comb begin
    full     = (cnt_q == CNT_W'(DEPTH));
    empty    = (cnt_q == '0);
    top_idx  = head_q + PTR_W'(cnt_q) - PTR_W'(1);
    tail_idx = head_q + PTR_W'(cnt_q);
    do_pop   = pop_i && !fl_q;
    do_push  = push_i && !pop_i && !fl_q;
  end

  // external port: write-out, spill, or underflow read
  always_comb begin
    mem_we_o    = 1'b0;
    mem_re_o    = 1'b0;
    mem_addr_o  = sp_q;
    mem_wdata_o = slot_q[head_q];
    if (fl_q) begin
      mem_we_o = 1'b1;
    end else if (do_push && full) begin
      mem_we_o = 1'b1;
    end else if (do_pop && empty) begin
      mem_re_o   = 1'b1;
      mem_addr_o = sp_q + SP_W'(1);
    end
    pop_data_o = empty ? mem_rdata_i : slot_q[top_idx];
  end

  always_comb begin
    head_d = head_q;
    cnt_d  = cnt_q;
    sp_d   = sp_q;
    fl_d   = fl_q;
    if (fl_q) begin
      head_d = head_q + PTR_W'(1);
      cnt_d  = cnt_q - CNT_W'(1);
      sp_d   = sp_q - SP_W'(1);
      fl_d   = (cnt_q != CNT_W'(1));
    end else begin
      if (do_pop) begin
        if (empty) sp_d  = sp_q + SP_W'(1);
        else       cnt_d = cnt_q - CNT_W'(1);
      end else if (do_push) begin
        if (full) begin
          head_d = head_q + PTR_W'(1);
          sp_d   = sp_q - SP_W'(1);
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      if (flush_i) fl_d = (cnt_d != '0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      cnt_q  <= '0;
      sp_q   <= SP_RST;
      fl_q   <= 1'b0;
    end else begin
      head_q <= head_d;
      cnt_q  <= cnt_d;
      sp_q   <= sp_d;
      fl_q   <= fl_d;
    end
  end

  // when full, tail_idx equals head_q: new byte takes the spilled slot
  always_ff @(posedge clk_i) begin
    if (do_push) slot_q[tail_idx] <= data_i;
  end

  assign busy_o = fl_q;
  assign sp_o   = sp_q;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH)); // R1
  AST_NO_EXT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !fl_q && !full) |-> (!mem_we_o && !mem_re_o)); // R1
  AST_SPILL_AT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !fl_q && full) |=> (sp_q == $past(sp_q) - SP_W'(1))); // R2
  AST_UNDERFLOW_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !fl_q && empty) |=> (sp_q == $past(sp_q) + SP_W'(1))); // R3
  AST_FLUSH_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_q |=> (sp_q == $past(sp_q) - SP_W'(1))); // R5
  AST_FLUSH_ENDS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fl_q) |-> (cnt_q == '0)); // R5
endmodule

// File: rtl/dis_irq_gate.sv
module dis_irq_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic boundary_i,
  input  logic busy_i,
  input  logic irq_i,
  input  logic nmi_i,
  output logic ack_o,
  output logic nmi_o
);
  logic pend_q, pend_nmi_q;

  assign ack_o = pend_q && !busy_i;
  assign nmi_o = ack_o && pend_nmi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      pend_nmi_q <= 1'b0;
    end else if (boundary_i) begin
      pend_q     <= irq_i || nmi_i;
      pend_nmi_q <= nmi_i;
    end else if (ack_o) begin
      pend_q     <= 1'b0;
      pend_nmi_q <= 1'b0;
    end
  end

  AST_ACK_AFTER_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> ($past(boundary_i) || $past(busy_i))); // R6
  AST_PEND_HELD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && busy_i) |=> pend_q); // R6
endmodule

// File: rtl/defer_irq_stack.sv
module defer_irq_stack
  import dis_pkg::*;
#(
  parameter int              DEPTH  = 8,
  parameter int              DATA_W = 8,
  parameter int              SP_W   = 8,
  parameter logic [SP_W-1:0] SP_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] push_data_i,
  output logic [DATA_W-1:0] pop_data_o,
  input  logic              instr_valid_i,
  input  logic [1:0]        instr_cls_i,
  input  logic              irq_i,
  input  logic              nmi_i,
  output logic              irq_ack_o,
  output logic              irq_nmi_o,
  output logic              busy_o,
  output logic [SP_W-1:0]   sp_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [SP_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic boundary;
  logic busy;

  dis_boundary_dec u_dec (
    .instr_valid_i(instr_valid_i),
    .instr_cls_i  (instr_cls_i),
    .busy_i       (busy),
    .boundary_o   (boundary)
  );

  dis_shadow_buf #(
    .DEPTH (DEPTH),
    .DATA_W(DATA_W),
    .SP_W  (SP_W),
    .SP_RST(SP_RST)
  ) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push_i),
    .pop_i      (pop_i),
    .data_i     (push_data_i),
    .flush_i    (boundary),
    .pop_data_o (pop_data_o),
    .busy_o     (busy),
    .sp_o       (sp_o),
    .mem_we_o   (mem_we_o),
    .mem_re_o   (mem_re_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i)
  );

  dis_irq_gate u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .boundary_i(boundary),
    .busy_i    (busy),
    .irq_i     (irq_i),
    .nmi_i     (nmi_i),
    .ack_o     (irq_ack_o),
    .nmi_o     (irq_nmi_o)
  );

  assign busy_o = busy;

  AST_BUSY_FROM_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(instr_valid_i && instr_cls_i == CLS_TAKEN)); // R5
  AST_NO_ACK_STRAIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !irq_ack_o && !(instr_valid_i && instr_cls_i == CLS_TAKEN)) |=> !irq_ack_o); // R4
  AST_WRITE_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (mem_we_o && mem_addr_o == sp_o)); // R5
endmodule

// File: tb/defer_irq_stack_bench.sv
module defer_irq_stack_bench;
  import dis_pkg::*;

  localparam int         DEPTH = 4;
  localparam logic [7:0] SPR   = 8'h20;
  localparam int         NVEC  = 14;

  // {op[35:34] 0=push 1=pop, data[33:26], we[25], re[24], addr[23:16], pdata[15:8], sp[7:0]}
  localparam logic [35:0] VEC [NVEC] = '{
    {2'd0, 8'hA1, 1'b0, 1'b0, 8'h00, 8'h00, 8'h20},
    {2'd0, 8'hA2, 1'b0, 1'b0, 8'h00, 8'h00, 8'h20},
    {2'd0, 8'hA3, 1'b0, 1'b0, 8'h00, 8'h00, 8'h20},
    {2'd0, 8'hA4, 1'b0, 1'b0, 8'h00, 8'h00, 8'h20},
    {2'd0, 8'hA5, 1'b1, 1'b0, 8'h20, 8'h00, 8'h1F},
    {2'd0, 8'hA6, 1'b1, 1'b0, 8'h1F, 8'h00, 8'h1E},
    {2'd1, 8'h00, 1'b0, 1'b0, 8'h00, 8'hA6, 8'h1E},
    {2'd1, 8'h00, 1'b0, 1'b0, 8'h00, 8'hA5, 8'h1E},
    {2'd1, 8'h00, 1'b0, 1'b0, 8'h00, 8'hA4, 8'h1E},
    {2'd1, 8'h00, 1'b0, 1'b0, 8'h00, 8'hA3, 8'h1E},
    {2'd1, 8'h00, 1'b0, 1'b1, 8'h1F, 8'hA2, 8'h1F},
    {2'd1, 8'h00, 1'b0, 1'b1, 8'h20, 8'hA1, 8'h20},
    {2'd0, 8'hB1, 1'b0, 1'b0, 8'h00, 8'h00, 8'h20},
    {2'd1, 8'h00, 1'b0, 1'b0, 8'h00, 8'hB1, 8'h20}
  };

  logic       clk, rst_n;
  logic       push, pop, iv, irq, nmi;
  logic [1:0] cls;
  logic [7:0] pdata_in, pop_data, mem_addr, mem_wdata, mem_rdata, sp;
  logic       ack, ack_nmi, busy, mem_we, mem_re;
  logic [7:0] ext_mem [256];

  int n_chk = 0;
  int n_bad = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) if (mem_we) ext_mem[mem_addr] <= mem_wdata;
  assign mem_rdata = ext_mem[mem_addr];

  defer_irq_stack #(.DEPTH(DEPTH), .DATA_W(8), .SP_W(8), .SP_RST(SPR)) u_defer_irq_stack (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push), .pop_i(pop), .push_data_i(pdata_in),
    .pop_data_o(pop_data), .instr_valid_i(iv), .instr_cls_i(cls), .irq_i(irq), .nmi_i(nmi),
    .irq_ack_o(ack), .irq_nmi_o(ack_nmi), .busy_o(busy), .sp_o(sp), .mem_we_o(mem_we),
    .mem_re_o(mem_re), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [35:0] v;
    string       rq;
    rst_n = 1'b0; push = 0; pop = 0; iv = 0; irq = 0; nmi = 0;
    cls = CLS_STRAIGHT; pdata_in = 8'h00;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(sp == SPR, "R9 reset sp", sp, SPR);
    chk(!busy && !ack && !ack_nmi, "R9 reset flags", {busy, ack, ack_nmi}, 0);
    chk(!mem_we && !mem_re, "R9 reset mem idle", {mem_we, mem_re}, 0);

    // table walk: R1 R2 R3
    for (int i = 0; i < NVEC; i++) begin
      v = VEC[i];
      @(negedge clk);
      push = (v[35:34] == 2'd0);
      pop  = (v[35:34] == 2'd1);
      pdata_in = v[33:26];
      rq = (v[35:34] == 2'd0) ? (v[25] ? "R2" : "R1") : (v[24] ? "R3" : "R1");
      #1;
      chk(mem_we == v[25], rq, mem_we, v[25]);
      chk(mem_re == v[24], rq, mem_re, v[24]);
      if (v[25] || v[24]) chk(mem_addr == v[23:16], rq, mem_addr, v[23:16]);
      if (pop) chk(pop_data == v[15:8], rq, pop_data, v[15:8]);
      @(posedge clk);
      #1;
      chk(sp == v[7:0], rq, sp, v[7:0]);
    end
    @(negedge clk);
    push = 0; pop = 0;

    // R4 then R5/R6 write-out with irq
    for (int k = 0; k < 3; k++) begin
      push = 1; pdata_in = 8'hC1 + 8'(k);
      @(negedge clk);
    end
    push = 0; irq = 1; iv = 1; cls = CLS_STRAIGHT;
    #1;
    chk(!ack && !busy && !mem_we, "R4 straight", {ack, busy, mem_we}, 0);
    @(negedge clk);
    cls = CLS_NOT_TAKEN;
    #1;
    chk(!ack && !busy && !mem_we, "R4 not taken", {ack, busy, mem_we}, 0);
    @(negedge clk);
    #1;
    chk(!ack && !busy, "R4 after not taken", {ack, busy}, 0);
    cls = CLS_TAKEN;
    @(negedge clk);
    iv = 0; irq = 0;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(busy && mem_we, "R5 busy write", {busy, mem_we}, 2'b11);
      chk(mem_addr == SPR - 8'(k), "R5 addr", mem_addr, SPR - 8'(k));
      chk(mem_wdata == 8'hC1 + 8'(k), "R5 oldest first", mem_wdata, 8'hC1 + 8'(k));
      chk(!ack, "R6 no ack while busy", ack, 0);
      @(negedge clk);
    end
    #1;
    chk(!busy, "R5 busy length", busy, 0);
    chk(ack, "R6 ack after flush", ack, 1);
    chk(!ack_nmi, "R7 irq only", ack_nmi, 0);
    chk(sp == 8'h1D, "R5 sp after flush", sp, 8'h1D);
    @(negedge clk);
    #1;
    chk(!ack, "R6 single pulse", ack, 0);
    chk(ext_mem[8'h1E] == 8'hC3, "R5 mem image", ext_mem[8'h1E], 8'hC3);

    // R6 empty buffer: accept next cycle, latched after irq drops
    iv = 1; cls = CLS_TAKEN; irq = 1;
    @(negedge clk);
    iv = 0; irq = 0;
    #1;
    chk(!busy && ack, "R6 empty accept", {busy, ack}, 2'b01);
    @(negedge clk);

    // R6 request gone by boundary
    iv = 1; cls = CLS_STRAIGHT; irq = 1;
    @(negedge clk);
    irq = 0; cls = CLS_TAKEN;
    @(negedge clk);
    iv = 0;
    #1;
    chk(!ack, "R6 missed request", ack, 0);
    @(negedge clk);
    #1;
    chk(!ack, "R6 missed request later", ack, 0);

    // R5 full depth after boundary, R8 push ignored while busy
    for (int k = 0; k < DEPTH; k++) begin
      push = 1; pdata_in = 8'hD0 + 8'(k);
      #1;
      chk(!mem_we, "R5 full depth free", mem_we, 0);
      @(negedge clk);
    end
    push = 0; iv = 1; cls = CLS_TAKEN;
    @(negedge clk);
    iv = 0; push = 1; pdata_in = 8'hEE;
    #1;
    chk(busy && mem_addr == 8'h1D && mem_wdata == 8'hD0, "R5 flush start", {busy, mem_addr, mem_wdata}, {1'b1, 8'h1D, 8'hD0});
    @(negedge clk);
    push = 0;
    for (int k = 1; k < DEPTH; k++) begin
      #1;
      chk(busy && mem_addr == 8'h1D - 8'(k), "R5 flush addr", mem_addr, 8'h1D - 8'(k));
      @(negedge clk);
    end
    #1;
    chk(!busy && !ack, "R6 no request no ack", {busy, ack}, 0);
    chk(sp == 8'h19, "R5 sp after full flush", sp, 8'h19);
    pop = 1;
    #1;
    chk(mem_re && mem_addr == 8'h1A, "R8 push during busy ignored", {mem_re, mem_addr}, {1'b1, 8'h1A});
    chk(pop_data == 8'hD3, "R8 pop data", pop_data, 8'hD3);
    @(negedge clk);
    pop = 0;
    #1;
    chk(sp == 8'h1A, "R3 sp inc", sp, 8'h1A);

    // R7 both requests
    iv = 1; cls = CLS_TAKEN; irq = 1; nmi = 1;
    @(negedge clk);
    iv = 0; irq = 0; nmi = 0;
    #1;
    chk(ack && ack_nmi, "R7 nmi priority", {ack, ack_nmi}, 2'b11);
    @(negedge clk);

    // R9 reset during write-out with pending request
    push = 1; pdata_in = 8'hF1;
    @(negedge clk);
    pdata_in = 8'hF2;
    @(negedge clk);
    push = 0; iv = 1; cls = CLS_TAKEN; irq = 1;
    @(negedge clk);
    iv = 0;
    #1;
    chk(busy, "R9 busy before reset", busy, 1);
    rst_n = 1'b0;
    #1;
    chk(!busy && sp == SPR, "R9 reset mid flush", {busy, sp}, {1'b0, SPR});
    @(negedge clk);
    irq = 0; rst_n = 1'b1;
    #1;
    chk(!ack, "R9 pending dropped", ack, 0);
    @(negedge clk);
    #1;
    chk(!ack, "R9 pending dropped later", ack, 0);
    pop = 1;
    #1;
    chk(mem_re && mem_addr == SPR + 8'd1, "R9 buffer cleared", {mem_re, mem_addr}, {1'b1, SPR + 8'd1});
    @(negedge clk);
    pop = 0;
    summary();
  end
endmodule